// File: doc/BRIEF.md
# Two-Bank SDRAM Command Decoder and Tracker

This block sits behind the command pins of a two-bank synchronous DRAM. It samples chip select, the three row/column/write strobes, a special-function flag, clock enable and an 11-bit address on every rising clock edge. It turns each accepted combination into a one-cycle decoded strobe: activate, read, write, precharge, auto refresh or self refresh. It also flags reads and writes aimed at a bank that has no open row.

For each bank it keeps an active/idle bit and the open row. Alongside these it holds the most recent row address, column address and bank number. It also gives a registered indication that clock enable was sampled low, meaning clock suspend or power down. All outputs are registered, so every result appears one clock after the edge that sampled the command. The memory array, data path, timing parameters and command scheduling live elsewhere.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While `cs_n` is sampled high, no strobe fires, and bank states, open rows and latched addresses stay as they were.
- R2: Address bit 10 picks the bank: 0 means bank 0 and 1 means bank 1. `bank_sel` shows the bank of the last activate, or of the last read or write that was accepted.
- R3: An activate opens the selected bank. Its open row, and `row_addr`, become address bits 9..0, and `act_stb` is high for one cycle.
- R4: A read or write to an active bank pulses `rd_stb` or `wr_stb` for one cycle and loads `col_addr` from address bits 7..0. Bank states do not change.
- R5: A read or write to an idle bank pulses `illegal_stb`. No read or write strobe fires, and bank states, open rows, `col_addr` and `bank_sel` keep their values.
- R6: A precharge with address bit 9 low idles only the selected bank and leaves the other bank unchanged.
- R7: A precharge with address bit 9 high idles both banks.
- R8: A refresh command pulses `aref_stb` when `cke` is high and `sref_stb` when `cke` is low, never both, and leaves bank states unchanged.
- R9: When `cke` is sampled low and the sampled command is not a refresh, `suspend` is high in the next cycle. Any other command on that edge is ignored, with no strobe and no state change. `suspend` is low after an edge where `cke` was high.
- R10: When `sf_flag` is sampled high, the command is not decoded as a plain command: no strobe fires and no state changes.
- R11: Commands are decoded from {`ras_n`,`cas_n`,`we_n`}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode register set. Mode register set and 111 (no operation) raise no strobe and change no state. At most one strobe is high in any cycle.
- R12: After a synchronous reset (`rst_n` low at a clock edge), both banks are idle, open rows and latched addresses are zero, and all strobes and `suspend` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, part of command code |
| cas_n | input | 1 | Column strobe, part of command code |
| we_n | input | 1 | Write strobe, part of command code |
| sf_flag | input | 1 | Special-function flag; low for plain commands |
| cke | input | 1 | Clock enable |
| addr | input | 11 | Row/column address, bit 9 all-bank precharge, bit 10 bank |
| act_stb | output | 1 | Activate accepted |
| rd_stb | output | 1 | Read to active bank accepted |
| wr_stb | output | 1 | Write to active bank accepted |
| pre_stb | output | 1 | Precharge accepted |
| aref_stb | output | 1 | Auto refresh accepted |
| sref_stb | output | 1 | Self refresh entry accepted |
| illegal_stb | output | 1 | Read or write to an idle bank |
| row_addr | output | 10 | Row of the last activate |
| col_addr | output | 8 | Column of the last accepted read or write |
| bank_sel | output | 1 | Bank of the last activate or accepted read/write |
| bank_active | output | 2 | Per-bank active bit, bank 0 in bit 0 |
| open_rows | output | 20 | Per-bank open row, bank 0 in bits 9..0 |
| suspend | output | 1 | Clock enable was low with no refresh command |

## Verification
Every combination of chip select, the three command strobes, the special-function flag, clock enable, bank bit and bit 9 is applied. The sweep is repeated from each of the four starting bank-state combinations, so the same code is seen against both idle and active target banks. This separates a legal read or write from an illegal one, and single-bank from all-bank precharge. It also shows that chip select, the special-function flag and clock enable each mask the command on their own. The address below bit 9 varies between vectors, so row and column latching, and their absence on masked commands, can be seen at the ports.

// File: rtl/sdr_cmd_pkg.sv
// Shared command type for the two-bank command decoder and tracker.
package sdr_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6
    } cmd_e;

endpackage

// File: rtl/sdr_cmd_decode.sv
// Combinational command decoder.
// Turns the sampled control pins into one command. cmd_raw ignores clock
// enable; cmd_o masks everything except refresh when clock enable is low.
// Assumes the pins are stable around the rising clock edge.
module sdr_cmd_decode
    import sdr_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic sf_flag,
    input  logic cke,
    output cmd_e cmd_raw,
    output cmd_e cmd_o
);

    // Decode the strobe code when chip select is low and the flag is clear.
    always_comb begin
        cmd_raw = CMD_NOP;
        if (!cs_n && !sf_flag) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd_raw = CMD_ACT;
                3'b101:  cmd_raw = CMD_RD;
                3'b100:  cmd_raw = CMD_WR;
                3'b010:  cmd_raw = CMD_PRE;
                3'b001:  cmd_raw = CMD_REF;
                3'b000:  cmd_raw = CMD_MRS;
                default: cmd_raw = CMD_NOP;
            endcase
        end
    end

    // With clock enable low only a refresh survives (as self refresh).
    always_comb begin
        cmd_o = cmd_raw;
        if (!cke && cmd_raw != CMD_REF) begin
            cmd_o = CMD_NOP;
        end
    end

endmodule

// File: rtl/sdr_bank_slot.sv
// State of one bank: active bit and open row.
// open_i latches row_i and marks the bank active; close_i marks it idle.
// Assumes open_i and close_i are never high together.
module sdr_bank_slot #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             active_o,
    output logic [ROW_W-1:0] row_o
);

    // Track active bit and open row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            row_o    <= '0;
        end else if (open_i) begin
            active_o <= 1'b1;
            row_o    <= row_i;
        end else if (close_i) begin
            active_o <= 1'b0;
        end
    end

    assert_open_latches_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        open_i |=> active_o && row_o == $past(row_i));

    assert_close_idles_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        close_i && !open_i |=> !active_o);

    assert_idle_cmd_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i && !close_i |=> $stable(active_o) && $stable(row_o));

endmodule

// File: rtl/sdram_cmd_tracker.sv
// Two-bank SDRAM command decoder and bank tracker.
// Decodes the command sampled at each rising edge and updates per-bank
// state. All outputs are registered: a command's effects appear one
// clock after the edge that sampled it. Address bit positions for bank
// select and all-bank precharge are parameters with fixed defaults.
module sdram_cmd_tracker
    import sdr_cmd_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int ROW_W      = 10,
    parameter int COL_W      = 8,
    parameter int BANK_W     = 1,
    parameter int ALLPRE_BIT = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic                          sf_flag,
    input  logic                          cke,
    input  logic [ADDR_W-1:0]             addr,
    output logic                          act_stb,
    output logic                          rd_stb,
    output logic                          wr_stb,
    output logic                          pre_stb,
    output logic                          aref_stb,
    output logic                          sref_stb,
    output logic                          illegal_stb,
    output logic [ROW_W-1:0]              row_addr,
    output logic [COL_W-1:0]              col_addr,
    output logic [BANK_W-1:0]             bank_sel,
    output logic [(1<<BANK_W)-1:0]        bank_active,
    output logic [(1<<BANK_W)*ROW_W-1:0]  open_rows,
    output logic                          suspend
);

    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int BANK_LSB  = ADDR_W - BANK_W;

    cmd_e                  cmd_raw;
    cmd_e                  cmd;
    logic [BANK_W-1:0]     bank_idx;
    logic                  all_pre;
    logic                  sel_active;
    logic                  rw_cmd;
    logic [NUM_BANKS-1:0]  open_v;
    logic [NUM_BANKS-1:0]  close_v;

    sdr_cmd_decode u_decode (
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .sf_flag (sf_flag),
        .cke     (cke),
        .cmd_raw (cmd_raw),
        .cmd_o   (cmd)
    );

    assign bank_idx   = addr[BANK_LSB +: BANK_W];
    assign all_pre    = addr[ALLPRE_BIT];
    assign sel_active = bank_active[bank_idx];
    assign rw_cmd     = (cmd == CMD_RD) || (cmd == CMD_WR);

    // Per-bank open and close requests.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            open_v[b]  = (cmd == CMD_ACT) && (bank_idx == BANK_W'(b));
            close_v[b] = (cmd == CMD_PRE) && (all_pre || bank_idx == BANK_W'(b));
        end
    end

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
            sdr_bank_slot #(.ROW_W(ROW_W)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .open_i   (open_v[g]),
                .close_i  (close_v[g]),
                .row_i    (addr[ROW_W-1:0]),
                .active_o (bank_active[g]),
                .row_o    (open_rows[g*ROW_W +: ROW_W])
            );
        end
    endgenerate

    // Register decoded strobes and the clock-enable indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_stb     <= 1'b0;
            rd_stb      <= 1'b0;
            wr_stb      <= 1'b0;
            pre_stb     <= 1'b0;
            aref_stb    <= 1'b0;
            sref_stb    <= 1'b0;
            illegal_stb <= 1'b0;
            suspend     <= 1'b0;
        end else begin
            act_stb     <= (cmd == CMD_ACT);
            rd_stb      <= (cmd == CMD_RD) && sel_active;
            wr_stb      <= (cmd == CMD_WR) && sel_active;
            pre_stb     <= (cmd == CMD_PRE);
            aref_stb    <= (cmd == CMD_REF) && cke;
            sref_stb    <= (cmd == CMD_REF) && !cke;
            illegal_stb <= rw_cmd && !sel_active;
            suspend     <= !cke && (cmd_raw != CMD_REF);
        end
    end

    // Latch row, column and bank of accepted commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_addr <= '0;
            col_addr <= '0;
            bank_sel <= '0;
        end else if (cmd == CMD_ACT) begin
            row_addr <= addr[ROW_W-1:0];
            bank_sel <= bank_idx;
        end else if (rw_cmd && sel_active) begin
            col_addr <= addr[COL_W-1:0];
            bank_sel <= bank_idx;
        end
    end

    assert_cs_high_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !(act_stb || rd_stb || wr_stb || pre_stb || aref_stb || sref_stb
                   || illegal_stb) && $stable(bank_active) && $stable(col_addr));

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_stb, rd_stb, wr_stb, pre_stb, aref_stb, sref_stb, illegal_stb}));

    assert_sref_needs_cke_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sref_stb |-> !$past(cke));

    assert_illegal_keeps_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_stb |-> $stable(col_addr) && $stable(bank_active) && $stable(bank_sel));

    assert_suspend_blocks_cmds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |-> !(act_stb || rd_stb || wr_stb || pre_stb || aref_stb || illegal_stb));

    assert_flag_high_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sf_flag |=> !(act_stb || rd_stb || wr_stb || pre_stb || aref_stb || sref_stb
                      || illegal_stb) && $stable(bank_active));

endmodule

// File: tb/test_sdram_cmd_tracker.sv
// Sweep bench: every control/bank/bit-9 combination from each bank-state start.
module test_sdram_cmd_tracker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        sf_flag = 1'b0, cke = 1'b1;
    logic [10:0] addr = '0;
    logic        act_stb, rd_stb, wr_stb, pre_stb, aref_stb, sref_stb, illegal_stb;
    logic [9:0]  row_addr;
    logic [7:0]  col_addr;
    logic [0:0]  bank_sel;
    logic [1:0]  bank_active;
    logic [19:0] open_rows;
    logic        suspend;

    int n_vec = 0;
    int n_bad = 0;

    // Reference model state
    logic [1:0] m_act = '0;
    logic [9:0] m_row0 = '0, m_row1 = '0, m_rowaddr = '0;
    logic [7:0] m_col = '0;
    logic       m_bank = 1'b0;

    sdram_cmd_tracker i_sdram_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .sf_flag(sf_flag), .cke(cke), .addr(addr),
        .act_stb(act_stb), .rd_stb(rd_stb), .wr_stb(wr_stb), .pre_stb(pre_stb),
        .aref_stb(aref_stb), .sref_stb(sref_stb), .illegal_stb(illegal_stb),
        .row_addr(row_addr), .col_addr(col_addr), .bank_sel(bank_sel),
        .bank_active(bank_active), .open_rows(open_rows), .suspend(suspend)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [6:0] e_stb, input logic e_susp);
        chk(tag, 32'({act_stb, rd_stb, wr_stb, pre_stb, aref_stb, sref_stb, illegal_stb}),
            32'(e_stb));
        chk(tag, 32'(bank_active), 32'(m_act));
        chk(tag, 32'(open_rows), 32'({m_row1, m_row0}));
        chk("R3", 32'(row_addr), 32'(m_rowaddr));
        chk("R4", 32'(col_addr), 32'(m_col));
        chk("R2", 32'(bank_sel), 32'(m_bank));
        chk("R9", 32'(suspend), 32'(e_susp));
    endtask

    // Apply one command (called at a negedge), predict, and check one clock later.
    task automatic step(input logic c, input logic r, input logic a, input logic w,
                        input logic f, input logic k, input logic [10:0] ad);
        logic       valid, is_ref, bk, a9, e_susp;
        logic [2:0] code;
        logic [6:0] e;
        int         op;
        string      tag;
        cs_n = c; ras_n = r; cas_n = a; we_n = w; sf_flag = f; cke = k; addr = ad;
        valid  = !c && !f;
        code   = {r, a, w};
        is_ref = valid && code == 3'b001;
        bk     = ad[10];
        a9     = ad[9];
        op = 0;
        if (valid) begin
            case (code)
                3'b011: op = 1;
                3'b101: op = 2;
                3'b100: op = 3;
                3'b010: op = 4;
                3'b001: op = 5;
                default: op = 0;
            endcase
        end
        if (!k && !is_ref) op = 0;
        e_susp = !k && !is_ref;
        e = '0;
        if (c) tag = "R1";
        else if (f) tag = "R10";
        else if (!k && !is_ref) tag = "R9";
        else tag = "R11";
        case (op)
            1: begin
                e[6] = 1'b1; tag = "R3";
                m_rowaddr = ad[9:0]; m_bank = bk;
                if (bk) begin m_act[1] = 1'b1; m_row1 = ad[9:0]; end
                else    begin m_act[0] = 1'b1; m_row0 = ad[9:0]; end
            end
            2, 3: begin
                if (m_act[bk]) begin
                    tag = "R4";
                    if (op == 2) e[5] = 1'b1; else e[4] = 1'b1;
                    m_col = ad[7:0]; m_bank = bk;
                end else begin
                    tag = "R5"; e[0] = 1'b1;
                end
            end
            4: begin
                e[3] = 1'b1;
                if (a9) begin tag = "R7"; m_act = 2'b00; end
                else begin tag = "R6"; m_act[bk] = 1'b0; end
            end
            5: begin
                tag = "R8";
                if (k) e[2] = 1'b1; else e[1] = 1'b1;
            end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        check_all(tag, e, e_susp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        check_all("R12", 7'b0, 1'b0);
        for (int s = 0; s < 4; s++) begin
            step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 11'h200);        // close both (R7)
            if (s[0]) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 11'(10'h155 + s));
            if (s[1]) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 11'h400 | 11'(10'h2AA - s));
            for (int v = 0; v < 256; v++) begin
                logic [7:0] vv;
                logic [8:0] low;
                vv  = 8'(v);
                low = 9'((v * 37 + s * 11 + 5) & 9'h1FF);
                step(vv[0], vv[1], vv[2], vv[3], vv[4], !vv[5], {vv[6], vv[7], low});
            end
        end
        // Directed: activate bank 1, then read it, then reset check again.
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 11'h5A5);
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 11'h43C);
        rst_n = 1'b0;
        cs_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_act = '0; m_row0 = '0; m_row1 = '0; m_rowaddr = '0; m_col = '0; m_bank = 1'b0;
        check_all("R12", 7'b0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule